// File: doc/BRIEF.md
# Page-Mode External Data Bus Sequencer

This block runs data-move reads and writes from a small CPU core over a multiplexed external memory bus. The high address byte sits on a dedicated high port. A shared low port carries the low address byte, which an external latch captures on the falling edge of the address-latch strobe, and then carries the data. The sequencer remembers the high byte of the previous external access. When a new request falls in the same 256-byte page, it skips the high-byte settle cycle. This makes page hits shorter than page misses.

A 3-bit stretch setting lengthens each access for slow devices. Each stretch unit is four clocks. At a setting of one, these clocks are shared between address setup, strobe width and hold. At higher settings, all of them go to the strobe. A request is taken only while the sequencer is idle. A one-clock done pulse follows each access, and for reads the captured byte is returned with it.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held and right after it, req_ready is 1, ale is 0, rd_n and wr_n are 1, lo_port_oe is 0 and done is 0.
- R2: Reset clears the remembered page, so the first access after reset is always a page miss, even if its high byte equals the one used before reset.
- R3: With stretch 0, a page hit keeps the sequencer busy (req_ready low) for 2 clocks and a page miss for 4 clocks.
- R4: A miss begins with one clock in which hi_port_out already shows the new high byte and ale is low. Every access has exactly one clock with ale high, during which lo_port_out is driven with the low address byte. hi_port_out does not change while busy.
- R5: Stretch 1 adds 4 clocks: 1 setup clock between ale and the strobe, a strobe 3 clocks wide, and 1 extra hold clock after it. Hold is 2 clocks on a miss and 1 on a hit.
- R6: With stretch 2 or 3, the strobe is 1 + 4·stretch clocks wide (9 or 13). There is no setup clock. Hold is 1 clock on a miss and none on a hit.
- R7: Stretch values 4 to 7 give the same timing as stretch 3.
- R8: On a write, wr_n is low for the strobe clocks, and lo_port_oe is 1 with lo_port_out equal to the write data during both the strobe and hold clocks.
- R9: On a read, rd_n is low for the strobe clocks and lo_port_oe is 0 during the strobe and hold. rdata takes the lo_port_in value present in the last strobe clock.
- R10: done is high for exactly one clock, in the first idle clock after an access. A req_valid raised while busy is ignored and does not change the remembered page.
- R11: rd_n and wr_n are never low together, and neither is low while ale is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | External data address |
| req_wdata | input | 8 | Write data |
| req_stretch | input | 3 | Stretch setting, sampled at acceptance |
| req_ready | output | 1 | Sequencer idle |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| hi_port_out | output | 8 | High address byte port |
| lo_port_out | output | 8 | Low address / write data port |
| lo_port_oe | output | 1 | Drive enable for the low port |
| lo_port_in | input | 8 | Read data from the low port |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume that inputs are 0 or 1 from the first clock. They also assume that request fields matter only in the clock when req_valid meets req_ready, because all later timing comes from the latched copy. The stimulus changes inputs only on falling edges and holds req_valid for one clock per access. It raises one request while busy on purpose, to show that it is ignored. The external memory is modelled by driving lo_port_in with the expected byte only while rd_n is low and with a filler value otherwise. This exposes a capture taken in the wrong clock.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int DATA_W       = 8;
    localparam int ADDR_W       = 16;
    localparam int PAGE_W       = ADDR_W - DATA_W;
    localparam int ST_W         = 3;
    localparam int STRETCH_CLKS = 4;
    localparam int MAX_STRETCH  = 3;
    localparam int EFF_W        = $clog2(MAX_STRETCH + 1);
    localparam int CNT_W        = $clog2(MAX_STRETCH * STRETCH_CLKS + 2);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PAGE,
        PH_ADDR,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic              we;
        logic              miss;
        logic [EFF_W-1:0]  stretch;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic [EFF_W-1:0] clamp_stretch(input logic [ST_W-1:0] s);
        if (int'(s) > MAX_STRETCH) return EFF_W'(MAX_STRETCH);
        return EFF_W'(s);
    endfunction

    function automatic logic [CNT_W-1:0] setup_len(input logic [EFF_W-1:0] s);
        return (s == EFF_W'(1)) ? CNT_W'(1) : CNT_W'(0);
    endfunction

    function automatic logic [CNT_W-1:0] strobe_len(input logic [EFF_W-1:0] s);
        if (s == '0)        return CNT_W'(1);
        if (s == EFF_W'(1)) return CNT_W'(1 + STRETCH_CLKS - 2);
        return CNT_W'(1 + int'(s) * STRETCH_CLKS);
    endfunction

    function automatic logic [CNT_W-1:0] hold_len(input logic miss, input logic [EFF_W-1:0] s);
        return CNT_W'(miss) + ((s == EFF_W'(1)) ? CNT_W'(1) : CNT_W'(0));
    endfunction

endpackage

// File: rtl/xbus_page_track.sv
module xbus_page_track
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [PAGE_W-1:0] page_in,
    output logic              hit,
    output logic [PAGE_W-1:0] page_q
);

    logic page_valid;

    assign hit = page_valid && (page_in == page_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_valid <= 1'b0;
            page_q     <= '0;
        end else if (accept) begin
            page_valid <= 1'b1;
            page_q     <= page_in;
        end
    end

endmodule

// File: rtl/xbus_phase_ctrl.sv
module xbus_phase_ctrl
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             acc_miss,
    input  logic             cur_miss,
    input  logic [EFF_W-1:0] cur_stretch,
    output phase_e           phase,
    output logic             strobe_last,
    output logic             xfer_end
);

    logic [CNT_W-1:0] cnt;
    phase_e           nxt;
    logic [CNT_W-1:0] nxt_len;

    always_comb begin
        nxt     = PH_IDLE;
        nxt_len = CNT_W'(1);
        unique case (phase)
            PH_PAGE: begin
                nxt     = PH_ADDR;
                nxt_len = CNT_W'(1);
            end
            PH_ADDR: begin
                if (setup_len(cur_stretch) != '0) begin
                    nxt     = PH_SETUP;
                    nxt_len = setup_len(cur_stretch);
                end else begin
                    nxt     = PH_STROBE;
                    nxt_len = strobe_len(cur_stretch);
                end
            end
            PH_SETUP: begin
                nxt     = PH_STROBE;
                nxt_len = strobe_len(cur_stretch);
            end
            PH_STROBE: begin
                if (hold_len(cur_miss, cur_stretch) != '0) begin
                    nxt     = PH_HOLD;
                    nxt_len = hold_len(cur_miss, cur_stretch);
                end
            end
            default: begin
                nxt     = PH_IDLE;
                nxt_len = CNT_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            cnt <= '0;
            if (accept) phase <= acc_miss ? PH_PAGE : PH_ADDR;
        end else if (cnt == '0) begin
            phase <= nxt;
            cnt   <= nxt_len - CNT_W'(1);
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign strobe_last = (phase == PH_STROBE) && (cnt == '0);
    assign xfer_end    = (phase != PH_IDLE) && (cnt == '0) && (nxt == PH_IDLE);

endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive
    import xbus_pkg::*;
(
    input  phase_e            phase,
    input  xfer_t             xfer,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              lo_oe,
    output logic [DATA_W-1:0] lo_out
);

    logic in_strobe;
    logic data_window;

    assign in_strobe   = (phase == PH_STROBE);
    assign data_window = in_strobe || (phase == PH_HOLD);

    always_comb begin
        ale    = (phase == PH_ADDR);
        rd_n   = !(in_strobe && !xfer.we);
        wr_n   = !(in_strobe &&  xfer.we);
        lo_oe  = ale || (xfer.we && data_window);
        lo_out = ale ? xfer.lo : xfer.wdata;
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ST_W-1:0]   req_stretch,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [PAGE_W-1:0] hi_port_out,
    output logic [DATA_W-1:0] lo_port_out,
    output logic              lo_port_oe,
    input  logic [DATA_W-1:0] lo_port_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);

    phase_e phase;
    xfer_t  xfer;
    logic   accept;
    logic   page_hit;
    logic   strobe_last;
    logic   xfer_end;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    xbus_page_track page_i (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .page_in (req_addr[ADDR_W-1:DATA_W]),
        .hit     (page_hit),
        .page_q  (hi_port_out)
    );

    xbus_phase_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .acc_miss    (!page_hit),
        .cur_miss    (xfer.miss),
        .cur_stretch (xfer.stretch),
        .phase       (phase),
        .strobe_last (strobe_last),
        .xfer_end    (xfer_end)
    );

    xbus_pin_drive pins_i (
        .phase  (phase),
        .xfer   (xfer),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .lo_oe  (lo_port_oe),
        .lo_out (lo_port_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer  <= '0;
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= xfer_end;
            if (accept) begin
                xfer.we      <= req_write;
                xfer.miss    <= !page_hit;
                xfer.stretch <= clamp_stretch(req_stretch);
                xfer.lo      <= req_addr[DATA_W-1:0];
                xfer.wdata   <= req_wdata;
            end
            if (strobe_last && !xfer.we) rdata <= lo_port_in;
        end
    end

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       done,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       lo_port_oe,
    input logic [7:0] hi_port_out
);

    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    a_r11_ale_quiet: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    a_r10_busy_strobe: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n || ale) |-> !req_ready);

    a_r8_write_drive: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> lo_port_oe);

    a_r9_read_release: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !lo_port_oe);

    a_r4_hi_stable: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(hi_port_out));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!ale && rd_n && wr_n && !lo_port_oe));

endmodule

bind xbus_seq xbus_seq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .done        (done),
    .ale         (ale),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .lo_port_oe  (lo_port_oe),
    .hi_port_out (hi_port_out)
);

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [2:0] req_stretch = '0;
    logic       req_ready, done, lo_port_oe, ale, rd_n, wr_n;
    logic [7:0] rdata, hi_port_out, lo_port_out;
    logic [7:0] lo_port_in = 8'hEE;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xbus_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_stretch(req_stretch),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .hi_port_out(hi_port_out), .lo_port_out(lo_port_out), .lo_port_oe(lo_port_oe),
        .lo_port_in(lo_port_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    typedef struct packed {
        logic       we;
        logic [15:0] addr;
        logic [7:0] wd;
        logic [2:0] st;
        logic       miss;
        logic [4:0] len;
        logic [7:0] rv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1234, 8'h00, 3'd0, 1'b1, 5'd4,  8'hA5},
        '{1'b0, 16'h1256, 8'h00, 3'd0, 1'b0, 5'd2,  8'h5A},
        '{1'b1, 16'h12AA, 8'hC3, 3'd1, 1'b0, 5'd6,  8'h00},
        '{1'b1, 16'h3400, 8'h3C, 3'd1, 1'b1, 5'd8,  8'h00},
        '{1'b0, 16'h3401, 8'h00, 3'd2, 1'b0, 5'd10, 8'h81},
        '{1'b0, 16'h5501, 8'h00, 3'd3, 1'b1, 5'd16, 8'h7E},
        '{1'b1, 16'h5502, 8'h99, 3'd7, 1'b0, 5'd14, 8'h00},
        '{1'b0, 16'h0002, 8'h00, 3'd2, 1'b1, 5'd12, 8'h42},
        '{1'b1, 16'h0003, 8'hF0, 3'd0, 1'b0, 5'd2,  8'h00}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic we, input logic [15:0] a, input logic [7:0] wd,
                         input logic [2:0] st);
        while (!req_ready) @(negedge clk);
        req_valid   = 1'b1;
        req_write   = we;
        req_addr    = a;
        req_wdata   = wd;
        req_stretch = st;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_access(input vec_t v);
        int busy = 0, pre = 0, n_ale = 0, setup = 0, strobe = 0, hold = 0;
        int eff, e_strobe, e_setup, e_hold;
        eff      = (v.st > 3) ? 3 : int'(v.st);
        e_setup  = (eff == 1) ? 1 : 0;
        e_strobe = (eff == 0) ? 1 : (eff == 1) ? 3 : 1 + 4 * eff;
        e_hold   = int'(v.miss) + ((eff == 1) ? 1 : 0);
        issue(v.we, v.addr, v.wd, v.st);
        chk(hi_port_out == v.addr[15:8], "R4 high byte on port", hi_port_out, v.addr[15:8]);
        while (!req_ready && busy < 64) begin
            busy++;
            lo_port_in = !rd_n ? v.rv : 8'hEE;
            if (ale) begin
                n_ale++;
                chk(lo_port_oe && lo_port_out == v.addr[7:0], "R4 low byte with ale",
                    lo_port_out, v.addr[7:0]);
            end else if (!rd_n || !wr_n) begin
                strobe++;
                if (v.we) chk(lo_port_oe && !wr_n && lo_port_out == v.wd, "R8 write data in strobe",
                              lo_port_out, v.wd);
                else      chk(!lo_port_oe && wr_n, "R9 port released in read strobe",
                              lo_port_oe, 0);
            end else if (strobe > 0) begin
                hold++;
                chk(v.we ? (lo_port_oe && lo_port_out == v.wd) : !lo_port_oe,
                    "R8/R9 hold drive", lo_port_oe, v.we);
            end else if (n_ale == 0) begin
                pre++;
            end else begin
                setup++;
            end
            @(negedge clk);
        end
        lo_port_in = 8'hEE;
        chk(busy == int'(v.len), "R3 R5 R6 R7 busy length", busy, v.len);
        chk(pre == int'(v.miss), "R2 R4 page settle clocks", pre, v.miss);
        chk(n_ale == 1, "R4 one ale clock", n_ale, 1);
        chk(setup == e_setup, "R5 setup clocks", setup, e_setup);
        chk(strobe == e_strobe, "R6 R7 strobe width", strobe, e_strobe);
        chk(hold == e_hold, "R5 R6 hold clocks", hold, e_hold);
        chk(done == 1'b1, "R10 done in first idle clock", done, 1);
        if (!v.we) chk(rdata == v.rv, "R9 read data", rdata, v.rv);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one clock", done, 0);
    endtask

    task automatic check_reset_state(input string tag);
        chk(req_ready && !ale && rd_n && wr_n && !lo_port_oe && !done, tag,
            {req_ready, ale, rd_n, wr_n, lo_port_oe, done}, 6'b101100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R1 outputs during reset");
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("R1 outputs after reset");

        for (int i = 0; i < NV; i++) run_access(VECS[i]);

        // R2: reset in the middle of an access to a page that is currently held
        issue(1'b0, 16'h0010, 8'h00, 3'd2);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state("R1 outputs during mid-access reset");
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("R1 idle after mid-access reset");
        run_access('{1'b0, 16'h0004, 8'h00, 3'd0, 1'b1, 5'd4, 8'h3D});

        // R10: a request raised while busy is ignored
        issue(1'b1, 16'h0020, 8'h11, 3'd1);
        req_valid = 1'b1;
        req_addr  = 16'h7711;
        req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(req_ready && !ale, "R10 busy request not started", req_ready, 1);
        run_access('{1'b0, 16'h0030, 8'h00, 3'd0, 1'b0, 5'd2, 8'hC6});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule